// File: doc/BRIEF.md
# UART Framed Register Slave

This block sits between a UART byte receiver and a UART byte transmitter and turns the incoming byte stream into register accesses. Each frame opens with a header byte. Bit 7 of the header selects read (1) or write (0), and bits 6:0 name the target. When the target matches the block's own identity parameter, the block collects a fixed, parameterized number of address bytes. After that it performs either a stream of writes or a counted burst of reads.

A UART link has no chip select to mark where a frame ends. A read frame therefore carries one count byte after the address. The block answers with the header byte first and then that many data bytes, read from consecutive addresses. A write frame has no length limit. It ends when the line stays silent for a parameterized number of clock cycles, and the parser then waits for a new header.

The register side is a plain strobe interface. `reg_wr` comes with `reg_addr` and `reg_wdata` in the same cycle. `reg_rd` comes with `reg_addr`, and the storage must present `reg_rdata` during the following cycle.

Top module: `uart_frame_regslave`

## Requirements
- R1: A header byte whose bits 6:0 equal `DEV_ID` starts a frame. Header bit 7 = 1 selects a read frame and bit 7 = 0 selects a write frame.
- R2: A frame whose header carries any other identity produces no `reg_wr`, no `reg_rd` and no `tx_valid` until the frame ends through the idle timeout.
- R3: The `ADDR_BYTES` bytes after the header form the start address, most significant byte first.
- R4: In a write frame, each byte after the address produces exactly one `reg_wr` in the cycle the byte is received. `reg_wdata` equals the byte, and `reg_addr` equals the start address plus the byte's index, wrapping modulo 2^(8*ADDR_BYTES). A write frame has no length limit.
- R5: If no byte is received for `IDLE_CYCLES` consecutive cycles after a byte of a frame, that frame ends and the next byte is taken as a header. A byte that arrives after a gap of `IDLE_CYCLES`-1 cycles still belongs to the frame.
- R6: In a read frame, the byte after the address is the count N. The block transmits the header byte, then N bytes read from the start address upward.
- R7: `reg_rd` is a single-cycle pulse. `reg_rdata` is sampled in the cycle after it, and `reg_rd` is never high while `tx_valid` is high.
- R8: Once `tx_valid` is high, it stays high with `tx_data` unchanged until a cycle in which `tx_ready` is high.
- R9: A read count of zero transmits only the header byte and issues no `reg_rd`.
- R10: After reset, `tx_valid`, `reg_rd` and `reg_wr` are low, and the first byte received is taken as a header.
- R11: Bytes received while a read response is in progress are ignored. They cause no write, and they do not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Received byte present for one cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| reg_addr | output | 8*ADDR_BYTES | Register address |
| reg_wr | output | 1 | Write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | Read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
Two events can collide in the same cycle. One is a received byte landing on exactly the cycle in which the idle counter would expire. The other is received bytes arriving while the transmitter is stalled in the middle of a read response. The bench provokes the first with gaps of exactly `IDLE_CYCLES`-1 and `IDLE_CYCLES` cycles: the shorter gap must still produce a write, and the longer gap must make the byte a fresh read header. It provokes the second by holding `tx_ready` low and injecting bytes shaped like a matching write frame during the response. It judges the result by the write log staying empty and the response bytes matching the model.

// File: rtl/uart_frame_regslave.sv
module uart_frame_regslave #(
  parameter logic [6:0] DEV_ID = 7'h2A,
  parameter int ADDR_BYTES = 2,
  parameter int IDLE_CYCLES = 32,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int IW = $clog2(IDLE_CYCLES + 1),
  localparam int BW = $clog2(ADDR_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr,
  output logic [7:0]    reg_wdata,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);
  typedef enum logic [3:0] {
    ST_HDR, ST_ADDR, ST_CNT, ST_WDATA, ST_SKIP, ST_ECHO, ST_RDREQ, ST_RDCAP, ST_TXD
  } st_t;

  st_t           st;
  logic [7:0]    hdr, remain, txbuf;
  logic [AW-1:0] addr;
  logic [BW-1:0] abyte;
  logic [IW-1:0] idle;

  wire parsing = (st == ST_ADDR) || (st == ST_CNT) || (st == ST_WDATA) || (st == ST_SKIP);
  wire timeout = parsing && !rx_valid && (idle == IW'(IDLE_CYCLES - 1));

  assign tx_valid  = (st == ST_ECHO) || (st == ST_TXD);
  assign tx_data   = (st == ST_ECHO) ? hdr : txbuf;
  assign reg_rd    = (st == ST_RDREQ);
  assign reg_wr    = (st == ST_WDATA) && rx_valid;
  assign reg_wdata = rx_data;
  assign reg_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_HDR;
      hdr    <= '0;
      remain <= '0;
      txbuf  <= '0;
      addr   <= '0;
      abyte  <= '0;
      idle   <= '0;
    end else begin
      if (!parsing || rx_valid) idle <= '0;
      else if (!timeout)        idle <= idle + 1'b1;

      case (st)
        ST_HDR: if (rx_valid) begin
          hdr   <= rx_data;
          abyte <= '0;
          addr  <= '0;
          st    <= (rx_data[6:0] == DEV_ID) ? ST_ADDR : ST_SKIP;
        end
        ST_ADDR:
          if (timeout) st <= ST_HDR;
          else if (rx_valid) begin
            addr <= (addr << 8) | AW'(rx_data);
            if (abyte == BW'(ADDR_BYTES - 1)) st <= hdr[7] ? ST_CNT : ST_WDATA;
            else abyte <= abyte + 1'b1;
          end
        ST_CNT:
          if (timeout) st <= ST_HDR;
          else if (rx_valid) begin
            remain <= rx_data;
            st     <= ST_ECHO;
          end
        ST_WDATA:
          if (timeout) st <= ST_HDR;
          else if (rx_valid) addr <= addr + 1'b1;
        ST_SKIP:
          if (timeout) st <= ST_HDR;
        ST_ECHO:
          if (tx_ready) st <= (remain == 8'd0) ? ST_HDR : ST_RDREQ;
        ST_RDREQ:
          st <= ST_RDCAP;
        ST_RDCAP: begin
          txbuf <= reg_rdata;
          st    <= ST_TXD;
        end
        ST_TXD:
          if (tx_ready) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
            st     <= (remain == 8'd1) ? ST_HDR : ST_RDREQ;
          end
        default: st <= ST_HDR;
      endcase
    end
  end
endmodule

// File: rtl/uart_frame_regslave_chk.sv
module uart_frame_regslave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       reg_rd,
  input logic       reg_wr
);
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_rd_not_during_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !tx_valid);

  assert_rd_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_rd_feeds_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> ##1 tx_valid);

  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R10: assert (!tx_valid && !reg_rd && !reg_wr);
  end
endmodule

bind uart_frame_regslave uart_frame_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/tb_uart_frame_regslave.sv
module tb_uart_frame_regslave;
  localparam logic [6:0] ID = 7'h2A;
  localparam int AB = 2;
  localparam int IDLE = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, reg_wr, reg_rd;
  logic [7:0] tx_data, reg_wdata;
  logic tx_ready = 1'b0;
  logic [7:0] reg_rdata = 8'h00;
  logic [15:0] reg_addr;
  logic stall = 1'b0;

  int n_chk = 0, n_fail = 0, rd_n = 0, hold_err = 0;
  logic [15:0] wr_a[$];
  logic [7:0]  wr_d[$];
  logic [7:0]  tx_log[$];
  logic prev_stall = 1'b0;
  logic [7:0] prev_d = 8'h00;

  always #4 clk = ~clk;

  uart_frame_regslave #(.DEV_ID(ID), .ADDR_BYTES(AB), .IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata));

  function automatic logic [7:0] model(logic [15:0] a);
    logic [15:0] t = a * 16'd13 + 16'd7;
    return t[7:0] ^ a[15:8];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin wr_a.push_back(reg_addr); wr_d.push_back(reg_wdata); end
      if (reg_rd) begin rd_n++; reg_rdata <= model(reg_addr); end
      if (tx_valid && tx_ready) tx_log.push_back(tx_data);
      if (prev_stall && !(tx_valid && tx_data == prev_d)) hold_err++;
      prev_stall = tx_valid && !tx_ready;
      prev_d = tx_data;
    end
  end

  always @(posedge clk) begin
    #1;
    tx_ready <= stall ? 1'b0 : (($urandom % 4) != 0);
  end

  task automatic put(input logic [7:0] b, input int gap);
    repeat (gap) begin @(posedge clk); #1; end
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic clear_logs();
    wr_a.delete(); wr_d.delete(); tx_log.delete(); rd_n = 0;
  endtask

  task automatic settle();
    repeat (IDLE + 4) begin @(posedge clk); #1; end
  endtask

  task automatic wframe(logic [6:0] id, logic [15:0] a, int n, int maxgap, string req);
    logic [7:0] ed[$];
    bit hit = (id == ID);
    clear_logs();
    put({1'b0, id}, 1);
    put(a[15:8], $urandom % maxgap);   // R3: high address byte first
    put(a[7:0], $urandom % maxgap);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      ed.push_back(d);
      put(d, $urandom % maxgap);
    end
    settle();
    check(wr_a.size() == (hit ? n : 0), req, "write count", wr_a.size(), hit ? n : 0);
    check(tx_log.size() == 0 && rd_n == 0, req, "write frame tx/rd activity", tx_log.size() + rd_n, 0);
    if (hit)
      for (int i = 0; i < n && i < wr_a.size(); i++)
        check(wr_a[i] == 16'(a + i) && wr_d[i] == ed[i], "R4", "write entry addr/data",
              {wr_a[i], wr_d[i]}, {16'(a + i), ed[i]});
  endtask

  task automatic rframe(logic [6:0] id, logic [15:0] a, int cnt, bit junk, string req);
    bit hit = (id == ID);
    clear_logs();
    if (junk) stall = 1'b1;
    put({1'b1, id}, 1);
    put(a[15:8], 0);
    put(a[7:0], 0);
    put(8'(cnt), 0);
    if (junk) begin
      put({1'b0, ID}, 0); put(8'h00, 0); put(8'h10, 0); put(8'hEE, 0);   // R11 injected bytes
      stall = 1'b0;
    end
    for (int k = 0; k < cnt * 30 + 80 && tx_log.size() < (hit ? cnt + 1 : 1); k++) begin
      @(posedge clk); #1;
    end
    settle();
    check(tx_log.size() == (hit ? cnt + 1 : 0), req, "tx byte count", tx_log.size(), hit ? cnt + 1 : 0);
    check(rd_n == (hit ? cnt : 0), req, "reg_rd count (R7)", rd_n, hit ? cnt : 0);
    check(wr_a.size() == 0, req, "writes during read frame", wr_a.size(), 0);
    if (hit && tx_log.size() == cnt + 1) begin
      check(tx_log[0] == {1'b1, id}, "R6", "echoed header", tx_log[0], {1'b1, id});
      for (int i = 0; i < cnt; i++)
        check(tx_log[i + 1] == model(16'(a + i)), "R6", "read data", tx_log[i + 1], model(16'(a + i)));
    end
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(!tx_valid && !reg_wr && !reg_rd, "R10", "outputs in reset", {tx_valid, reg_wr, reg_rd}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(!tx_valid && !reg_wr && !reg_rd, "R10", "outputs after reset", {tx_valid, reg_wr, reg_rd}, 0);

    // R1/R10: first byte after reset is a header
    wframe(ID, 16'h1234, 4, 3, "R1");
    rframe(ID, 16'h1234, 3, 1'b0, "R1");
    // R2: other identities stay silent
    wframe(7'h11, 16'h0040, 5, 3, "R2");
    rframe(7'h55, 16'h0040, 4, 1'b0, "R2");
    // R9: zero count
    rframe(ID, 16'h0200, 0, 1'b0, "R9");
    // R11: bytes during stalled response
    rframe(ID, 16'h0300, 3, 1'b1, "R11");
    // R4: wrap of address
    wframe(ID, 16'hFFFE, 4, 2, "R4");
    rframe(ID, 16'hFFFF, 2, 1'b0, "R6");
    // R4: long write frame
    wframe(ID, 16'h0500, 40, 6, "R4");

    // R5: gap IDLE-1 continues the frame, gap IDLE ends it
    clear_logs();
    put({1'b0, ID}, 1); put(8'h01, 0); put(8'h00, 0);
    put(8'hA1, 0);
    put(8'hB2, IDLE - 1);
    put({1'b1, ID}, IDLE);
    put(8'h00, 0); put(8'h10, 0); put(8'h02, 0);
    for (int k = 0; k < 200 && tx_log.size() < 3; k++) begin @(posedge clk); #1; end
    settle();
    check(wr_a.size() == 2, "R5", "writes across gaps", wr_a.size(), 2);
    if (wr_a.size() == 2)
      check(wr_a[1] == 16'h0101 && wr_d[1] == 8'hB2, "R5", "byte after IDLE-1 gap", {wr_a[1], wr_d[1]}, {16'h0101, 8'hB2});
    check(tx_log.size() == 3, "R5", "byte after IDLE gap is header", tx_log.size(), 3);
    if (tx_log.size() == 3)
      check(tx_log[0] == {1'b1, ID} && tx_log[1] == model(16'h0010) && tx_log[2] == model(16'h0011),
            "R5", "new read frame response", tx_log[2], model(16'h0011));

    // Random mix
    for (int f = 0; f < 24; f++) begin
      logic [6:0] id = (($urandom % 5) == 0) ? 7'($urandom) : ID;
      logic [15:0] a = 16'($urandom);
      if ($urandom % 2) wframe(id, a, $urandom % 7, 5, "R4");
      else rframe(id, a, $urandom % 6, 1'b0, "R6");
    end

    check(hold_err == 0, "R8", "tx hold violations", hold_err, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule